// File: doc/BRIEF.md
# Sized Data Breakpoint Comparator

This block watches every data access the processor puts on its 32-bit data bus and compares the addressed part of the bus with a programmed breakpoint value. Two independent trigger levels share the value and an optional don't-care mask. Each level has its own 8-bit configuration byte and its own enable. The configuration byte chooses which access sizes and byte or halfword positions may fire, and whether the level fires on a match or on a mismatch.

A comparison counts only when the access's real size and lane are selected in the configuration. A byte access compares only the byte lane its address points at. A word access compares only the halfword its address points at. A longword access compares the whole bus. The value on any other lane has no effect. Address-range and program-counter checks are made elsewhere and arrive as one address-qualify input. Each level's result is registered into a single-cycle pulse and goes to a trigger sequencer.

The block has no state machine. Its flow is: capture the access, align the addressed lane, compare under the size mask, then register the result.

Top module: `dbc_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset is released, `lvl1_hit` and `lvl2_hit` are 0.
- R2: For a byte access (`acc_size`=00), configuration bit 4+i enables lane i, where i = `acc_addr_lo`. Lanes are numbered big-endian: lane 0 is `acc_data[31:24]` and lane 3 is `acc_data[7:0]`. The lane byte is compared with `bp_value[7:0]`.
- R3: If several lane bits are set, a byte access fires only when the value sits on the lane the address selects. The same value on another lane does not fire. A byte access to a lane whose bit is clear never fires.
- R4: For a word access (`acc_size`=01), configuration bit 2 enables the halfword at `acc_addr_lo[1]`=0 (`acc_data[31:16]`). Configuration bit 3 enables the halfword at `acc_addr_lo[1]`=1 (`acc_data[15:0]`). The halfword is compared with `bp_value[15:0]`.
- R5: For a longword access (`acc_size`=10), configuration bit 1 enables a compare of all 32 bits with `bp_value`.
- R6: A bit set in `bp_mask` excludes the matching bit of `bp_value` from the compare. The mask is right-aligned in the same way as the value.
- R7: Configuration bit 0 inverts the result. A qualified access of any size then fires when its data does not match.
- R8: An access whose size or position has no selection bit set, or whose `acc_size` is 11, never fires, with or without inversion.
- R9: A level fires only when `acc_valid`, `acc_addr_hit` and that level's enable are all 1 in the access cycle.
- R10: A hit appears one clock after the access is sampled and lasts exactly one cycle per qualifying access. The two levels are evaluated independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A data access is on the bus this cycle |
| acc_addr_hit | input | 1 | The address qualifier accepts this access |
| acc_addr_lo | input | 2 | Low address bits of the access |
| acc_size | input | 2 | 00 byte, 01 word, 10 longword, 11 reserved |
| acc_data | input | 32 | Data bus value |
| bp_value | input | 32 | Breakpoint data value, right-aligned |
| bp_mask | input | 32 | Don't-care bits of the value, right-aligned |
| lvl1_en | input | 1 | Enable for level 1 |
| lvl1_cfg | input | 8 | Level 1 configuration: [7:4] lanes, [3:2] halves, [1] longword, [0] invert |
| lvl2_en | input | 1 | Enable for level 2 |
| lvl2_cfg | input | 8 | Level 2 configuration, same layout as level 1 |
| lvl1_hit | output | 1 | Registered level-1 match pulse |
| lvl2_hit | output | 1 | Registered level-2 match pulse |

## Verification
The assertions assume that every input is known and stable around each rising edge. They also assume that the configuration, value and mask belong to the access sampled in the same cycle, so that no update lands half-way through a compare. The bench drives every input, configuration included, only at the falling edge from shadow copies. Each scoreboard entry is therefore computed from exactly the set of values that the design registers at the next rising edge.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [3:0] lane;
        logic [1:0] half;
        logic       long_sel;
        logic       invert;
    } lvl_cfg_t;
endpackage

// File: rtl/dbc_lane_align.sv
module dbc_lane_align
    import dbc_pkg::*;
#(
    parameter int BUS_W = DATA_W
) (
    input  acc_size_e          size,
    input  logic [1:0]         addr_lo,
    input  logic [BUS_W-1:0]   bus,
    output logic [BUS_W-1:0]   aligned,
    output logic [BUS_W-1:0]   size_mask
);
    localparam logic [BUS_W-1:0] BYTE_M = {{(BUS_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
    localparam logic [BUS_W-1:0] HALF_M = {{(BUS_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    always_comb begin
        aligned   = '0;
        size_mask = '0;
        unique case (size)
            SZ_BYTE: begin
                aligned[LANE_W-1:0] = bus[(BUS_W-1) - LANE_W*int'(addr_lo) -: LANE_W];
                size_mask = BYTE_M;
            end
            SZ_WORD: begin
                aligned[HALF_W-1:0] = bus[(BUS_W-1) - HALF_W*int'(addr_lo[1]) -: HALF_W];
                size_mask = HALF_M;
            end
            SZ_LONG: begin
                aligned   = bus;
                size_mask = '1;
            end
            default: begin
                aligned   = '0;
                size_mask = '0;
            end
        endcase
    end
endmodule

// File: rtl/dbc_level_cmp.sv
module dbc_level_cmp
    import dbc_pkg::*;
#(
    parameter int BUS_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_qual,
    input  logic              lvl_en,
    input  lvl_cfg_t          cfg,
    input  acc_size_e         size,
    input  logic [1:0]        addr_lo,
    input  logic [BUS_W-1:0]  aligned,
    input  logic [BUS_W-1:0]  size_mask,
    input  logic [BUS_W-1:0]  value,
    input  logic [BUS_W-1:0]  mask,
    output logic              hit
);
    logic sel;
    logic eq;
    logic hit_d;

    always_comb begin
        unique case (size)
            SZ_BYTE: sel = cfg.lane[addr_lo];
            SZ_WORD: sel = cfg.half[addr_lo[1]];
            SZ_LONG: sel = cfg.long_sel;
            default: sel = 1'b0;
        endcase
    end

    assign eq    = (((aligned ^ value) & ~mask & size_mask) == '0);
    assign hit_d = acc_qual & lvl_en & sel & (eq ^ cfg.invert);

    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= hit_d;
    end

    // R8: reserved size never fires
    a_r8_rsvd_size: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_RSVD) |=> !hit);

    // R9: no qualified access with enable, no hit
    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_qual && lvl_en) |=> !hit);
endmodule

// File: rtl/dbc_top.sv
module dbc_top
    import dbc_pkg::*;
#(
    parameter int BUS_W  = DATA_W,
    parameter int LEVELS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_addr_hit,
    input  logic [1:0]        acc_addr_lo,
    input  logic [1:0]        acc_size,
    input  logic [BUS_W-1:0]  acc_data,
    input  logic [BUS_W-1:0]  bp_value,
    input  logic [BUS_W-1:0]  bp_mask,
    input  logic              lvl1_en,
    input  logic [7:0]        lvl1_cfg,
    input  logic              lvl2_en,
    input  logic [7:0]        lvl2_cfg,
    output logic              lvl1_hit,
    output logic              lvl2_hit
);
    acc_size_e         size_e;
    logic [BUS_W-1:0]  aligned;
    logic [BUS_W-1:0]  size_mask;
    logic              acc_qual;
    lvl_cfg_t          cfg_arr [LEVELS];
    logic [LEVELS-1:0] en_arr;
    logic [LEVELS-1:0] hit_arr;

    assign size_e     = acc_size_e'(acc_size);
    assign acc_qual   = acc_valid & acc_addr_hit;
    assign cfg_arr[0] = lvl_cfg_t'(lvl1_cfg);
    assign cfg_arr[1] = lvl_cfg_t'(lvl2_cfg);
    assign en_arr     = {lvl2_en, lvl1_en};

    dbc_lane_align #(.BUS_W(BUS_W)) u_align (
        .size      (size_e),
        .addr_lo   (acc_addr_lo),
        .bus       (acc_data),
        .aligned   (aligned),
        .size_mask (size_mask)
    );

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        dbc_level_cmp #(.BUS_W(BUS_W)) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_qual  (acc_qual),
            .lvl_en    (en_arr[g]),
            .cfg       (cfg_arr[g]),
            .size      (size_e),
            .addr_lo   (acc_addr_lo),
            .aligned   (aligned),
            .size_mask (size_mask),
            .value     (bp_value),
            .mask      (bp_mask),
            .hit       (hit_arr[g])
        );
    end

    assign lvl1_hit = hit_arr[0];
    assign lvl2_hit = hit_arr[1];

    // R3: byte access to a lane whose bit is clear never fires
    a_r3_lane_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b00 && !lvl1_cfg[4 + int'(acc_addr_lo)]) |=> !lvl1_hit);

    // R10: a hit always follows a valid access
    a_r10_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl1_hit || lvl2_hit) |-> $past(acc_valid));
endmodule

// File: tb/tb_dbc_top.sv
module tb_dbc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_addr_hit = 1'b0;
    logic [1:0]  acc_addr_lo = '0, acc_size = '0;
    logic [31:0] acc_data = '0, bp_value = '0, bp_mask = '0;
    logic        lvl1_en = 1'b0, lvl2_en = 1'b0;
    logic [7:0]  lvl1_cfg = '0, lvl2_cfg = '0;
    logic        lvl1_hit, lvl2_hit;

    logic        s_en1 = 1'b1, s_en2 = 1'b1;
    logic [7:0]  s_cfg1 = '0, s_cfg2 = '0;
    logic [31:0] s_val = '0, s_msk = '0;

    int total = 0;
    int bad = 0;

    typedef struct { string tag; bit h1; bit h2; } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    dbc_top dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr_hit(acc_addr_hit),
        .acc_addr_lo(acc_addr_lo), .acc_size(acc_size), .acc_data(acc_data),
        .bp_value(bp_value), .bp_mask(bp_mask), .lvl1_en(lvl1_en), .lvl1_cfg(lvl1_cfg),
        .lvl2_en(lvl2_en), .lvl2_cfg(lvl2_cfg), .lvl1_hit(lvl1_hit), .lvl2_hit(lvl2_hit)
    );

    function automatic bit model(bit v, bit aq, bit en, logic [7:0] cfg, logic [1:0] sz,
                                 logic [1:0] a, logic [31:0] d, logic [31:0] val, logic [31:0] msk);
        logic [31:0] ext, wm;
        bit sel;
        ext = '0; wm = '0; sel = 0;
        case (sz)
            2'b00: begin sel = cfg[4 + a]; ext = (d >> (8 * (3 - a))) & 32'hFF; wm = 32'hFF; end
            2'b01: begin sel = cfg[2 + a[1]]; ext = a[1] ? {16'h0, d[15:0]} : {16'h0, d[31:16]}; wm = 32'hFFFF; end
            2'b10: begin sel = cfg[1]; ext = d; wm = 32'hFFFF_FFFF; end
            default: sel = 0;
        endcase
        return v & aq & en & sel & ((((ext ^ val) & ~msk & wm) == 0) ^ cfg[0]);
    endfunction

    task automatic drive(string tag, logic [1:0] sz, logic [1:0] a, logic [31:0] d,
                         bit v = 1, bit aq = 1);
        exp_t e;
        @(negedge clk);
        acc_valid = v; acc_addr_hit = aq; acc_size = sz; acc_addr_lo = a; acc_data = d;
        lvl1_en = s_en1; lvl2_en = s_en2; lvl1_cfg = s_cfg1; lvl2_cfg = s_cfg2;
        bp_value = s_val; bp_mask = s_msk;
        e.tag = tag;
        e.h1 = model(v, aq, s_en1, s_cfg1, sz, a, d, s_val, s_msk);
        e.h2 = model(v, aq, s_en2, s_cfg2, sz, a, d, s_val, s_msk);
        sb.push_back(e);
    endtask

    // monitor: 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (lvl1_hit !== e.h1 || lvl2_hit !== e.h2) begin
                    bad++;
                    $display("FAIL %s: got l1=%b l2=%b expected l1=%b l2=%b",
                             e.tag, lvl1_hit, lvl2_hit, e.h1, e.h2);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        total++;
        if (lvl1_hit !== 1'b0 || lvl2_hit !== 1'b0) begin
            bad++;
            $display("FAIL R1: got l1=%b l2=%b expected 0 0", lvl1_hit, lvl2_hit);
        end
        @(negedge clk);
        rst_n = 1'b1;
        drive("R1 first cycle idle", 2'b10, 2'b00, 32'h0, 0, 0);

        // R5 longword
        s_cfg1 = 8'h02; s_cfg2 = 8'h00; s_val = 32'h1234_5678; s_msk = '0;
        drive("R5 long match", 2'b10, 2'b00, 32'h1234_5678);
        drive("R5 long miss", 2'b10, 2'b00, 32'h1234_5679);

        // R2 byte lanes, big-endian
        s_cfg1 = 8'hF0; s_val = 32'h0000_00AB;
        drive("R2 byte lane0", 2'b00, 2'b00, 32'hAB00_0000);
        drive("R2 byte lane2", 2'b00, 2'b10, 32'h0000_AB00);
        drive("R2 byte lane3", 2'b00, 2'b11, 32'h0000_00AB);
        // R3 wrong lane
        drive("R3 value on other lane", 2'b00, 2'b01, 32'h0000_00AB);
        s_cfg1 = 8'h10;
        drive("R3 lane bit clear", 2'b00, 2'b01, 32'h00AB_0000);

        // R4 words
        s_cfg1 = 8'h0C; s_val = 32'h0000_BEEF;
        drive("R4 word upper half", 2'b01, 2'b00, 32'hBEEF_0000);
        drive("R4 word lower half", 2'b01, 2'b10, 32'h0000_BEEF);
        drive("R4 word other half", 2'b01, 2'b10, 32'hBEEF_0000);
        s_cfg1 = 8'h04;
        drive("R4 half bit clear", 2'b01, 2'b10, 32'h0000_BEEF);

        // R6 mask
        s_cfg1 = 8'h02; s_val = 32'h1234_5678; s_msk = 32'h0000_00FF;
        drive("R6 masked long", 2'b10, 2'b00, 32'h1234_56AA);
        drive("R6 unmasked bit differs", 2'b10, 2'b00, 32'h1334_56AA);
        s_msk = '0;

        // R7 inversion on all sizes
        s_cfg1 = 8'h03;
        drive("R7 invert long miss", 2'b10, 2'b00, 32'h0);
        drive("R7 invert long match", 2'b10, 2'b00, 32'h1234_5678);
        s_cfg1 = 8'h0D; s_val = 32'h0000_BEEF;
        drive("R7 invert word miss", 2'b01, 2'b00, 32'h1111_BEEF);
        drive("R7 invert word match", 2'b01, 2'b10, 32'h1111_BEEF);
        s_cfg1 = 8'hF1; s_val = 32'h0000_00AB;
        drive("R7 invert byte miss", 2'b00, 2'b01, 32'h00CD_0000);

        // R8 unselected size / reserved
        drive("R8 word with byte-only cfg", 2'b01, 2'b00, 32'h0);
        s_cfg1 = 8'hFF;
        drive("R8 reserved size", 2'b11, 2'b00, 32'h0);

        // R9 gating
        s_cfg1 = 8'h02; s_val = 32'h1234_5678;
        drive("R9 not valid", 2'b10, 2'b00, 32'h1234_5678, 0, 1);
        drive("R9 addr not qualified", 2'b10, 2'b00, 32'h1234_5678, 1, 0);
        s_en1 = 0;
        drive("R9 level disabled", 2'b10, 2'b00, 32'h1234_5678);
        s_en1 = 1;

        // R10 independent levels and single-cycle pulses
        s_cfg2 = 8'h03;
        drive("R10 l1 hit l2 invert miss", 2'b10, 2'b00, 32'h1234_5678);
        drive("R10 l2 only", 2'b10, 2'b00, 32'h0);
        drive("R10 back to back", 2'b10, 2'b00, 32'h1234_5678);
        drive("R10 pulse ends", 2'b10, 2'b00, 32'h0, 0, 0);
        drive("R10 idle", 2'b00, 2'b00, 32'h0, 0, 0);

        @(negedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule